// File: doc/BRIEF.md
# Bang-Bang Phase Detector with Digital Loop Control

This block makes the phase decision for a clock and data recovery loop. Each unit interval it receives three samples of the incoming stream, along with a strobe that marks them valid. The first sample, `smp_mid`, is taken at the centre of the current bit. The second, `smp_edge`, is taken at the expected transition. The third, `smp_next`, is taken at the centre of the following bit. From these three samples it decides whether the recovered clock is running early or late. It then issues a one-cycle slow-down or speed-up pulse and retimes the data bit.

The block also keeps a signed oscillator control word. That word is the sum of two parts:
- a saturating integral term, which tracks the centre frequency;
- a fixed proportional kick, which is present only during the cycle in which a decision pulse is high.

A frequency acquisition block drives `acq_ok`. While `acq_ok` is low, no phase decisions are issued and the integral term holds its value.

Top module: `bangbang_pd`

## Requirements
- R1: When `smp_mid` equals `smp_next` (no transition), neither `pd_up` nor `pd_dn` is asserted and the integral term does not change.
- R2: When `smp_mid` equals `smp_edge` but `smp_next` differs (clock early), `pd_dn` is high for the cycle after the strobe edge.
- R3: When `smp_next` equals `smp_edge` but `smp_mid` differs (clock late), `pd_up` is high for the cycle after the strobe edge.
- R4: `rx_bit` takes the value of `smp_mid` at each valid strobe and holds it between strobes.
- R5: `pd_up` and `pd_dn` are never high together, and both are low after any clock edge without a valid strobe.
- R6: `ctrl_word` equals the integral term plus `KICK` while `pd_up` is high, minus `KICK` while `pd_dn` is high, and the integral term alone otherwise.
- R7: Each up decision adds `GAIN_I` to the integral term and each down decision subtracts it, effective in the same cycle as the pulse.
- R8: The integral term saturates at +`INT_LIM` and −`INT_LIM` instead of wrapping.
- R9: While `acq_ok` is low at a strobe edge, no up or down pulse is produced and the integral term holds; `rx_bit` still updates.
- R10: A synchronous active-high `rst` clears `pd_up`, `pd_dn`, `rx_bit`, the integral term and `ctrl_word` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per unit interval |
| rst | input | 1 | Synchronous active-high reset |
| smp_mid | input | 1 | Sample at the centre of the current bit |
| smp_edge | input | 1 | Sample at the nominal transition point |
| smp_next | input | 1 | Sample at the centre of the next bit |
| smp_vld | input | 1 | The three samples are valid this cycle |
| acq_ok | input | 1 | Frequency acquisition permits phase decisions |
| pd_up | output | 1 | Speed-up pulse (clock late) |
| pd_dn | output | 1 | Slow-down pulse (clock early) |
| rx_bit | output | 1 | Retimed data bit |
| ctrl_word | output | CW | Signed oscillator control word |

## Verification
Every result of this block is due exactly one rising edge after the strobe that produced it:
- the pulses;
- the retimed bit;
- the updated integral term and therefore `ctrl_word`.

Only the proportional kick disappears on the following edge if no new strobe arrives. The bench therefore drives all inputs on the falling edge and lets one rising edge pass. It then compares all four outputs on the next falling edge against a model that it advances at that same rising edge. Between strobes, that comparison also shows the pulses cleared and the integral term holding.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_SLOW = 2'd1,
        DIR_FAST = 2'd2
    } pd_dir_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic bit_q;
    } pd_out_t;

    // Three-point vote: no transition -> hold; edge sample agrees with
    // current bit -> clock early (slow down); otherwise clock late.
    function automatic pd_dir_e pd_vote(input logic mid, input logic edg, input logic nxt);
        if (mid == nxt)      return DIR_HOLD;
        else if (edg == mid) return DIR_SLOW;
        else                 return DIR_FAST;
    endfunction

    function automatic int sat_step(input int cur, input int delta, input int lim);
        int s;
        s = cur + delta;
        if (s > lim)  s = lim;
        if (s < -lim) s = -lim;
        return s;
    endfunction

endpackage

// File: rtl/bbpd_vote.sv
module bbpd_vote
    import bbpd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_mid,
    input  logic    smp_edge,
    input  logic    smp_next,
    input  logic    smp_vld,
    input  logic    acq_ok,
    output logic    step_up,
    output logic    step_dn,
    output pd_out_t out_q
);

    pd_dir_e dir;

    always_comb begin
        dir     = pd_vote(smp_mid, smp_edge, smp_next);
        step_up = smp_vld && acq_ok && (dir == DIR_FAST);
        step_dn = smp_vld && acq_ok && (dir == DIR_SLOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.up <= step_up;
            out_q.dn <= step_dn;
            if (smp_vld) out_q.bit_q <= smp_mid;
        end
    end

    // R5: pulses exclusive
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_q.up && out_q.dn));

    // R5: no strobe -> no pulse on the next cycle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp_vld)) |-> (!out_q.up && !out_q.dn));

    // R9: acquisition gate blocks decisions
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(acq_ok)) |-> (!out_q.up && !out_q.dn));

    // R1: no transition -> no pulse
    a_r1_no_transition: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(smp_mid == smp_next)) |-> (!out_q.up && !out_q.dn));

endmodule

// File: rtl/bbpd_integ.sv
module bbpd_integ
    import bbpd_pkg::*;
#(
    parameter int CW      = 16,
    parameter int GAIN_I  = 4,
    parameter int INT_LIM = 2000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_up,
    input  logic                 step_dn,
    output logic signed [CW-1:0] integ_o
);

    int delta;
    int next_val;

    always_comb begin
        delta    = step_up ? GAIN_I : (step_dn ? -GAIN_I : 0);
        next_val = sat_step(int'(integ_o), delta, INT_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) integ_o <= '0;
        else     integ_o <= CW'(next_val);
    end

    // R8: bounded
    a_r8_bounds: assert property (@(posedge clk) disable iff (rst)
        (int'(integ_o) <= INT_LIM) && (int'(integ_o) >= -INT_LIM));

    // R7: holds without a step
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step_up) && !$past(step_dn)) |-> $stable(integ_o));

endmodule

// File: rtl/bbpd_mix.sv
module bbpd_mix #(
    parameter int CW   = 16,
    parameter int KICK = 64
) (
    input  logic signed [CW-1:0] integ_i,
    input  logic                 up_i,
    input  logic                 dn_i,
    output logic signed [CW-1:0] word_o
);

    localparam logic signed [CW-1:0] KICK_W = CW'(KICK);

    logic signed [CW-1:0] kick;

    always_comb begin
        if (up_i)      kick = KICK_W;
        else if (dn_i) kick = -KICK_W;
        else           kick = '0;
        word_o = integ_i + kick;
    end

endmodule

// File: rtl/bangbang_pd.sv
module bangbang_pd
    import bbpd_pkg::*;
#(
    parameter int CW      = 16,
    parameter int KICK    = 64,
    parameter int GAIN_I  = 4,
    parameter int INT_LIM = 2000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_mid,
    input  logic                 smp_edge,
    input  logic                 smp_next,
    input  logic                 smp_vld,
    input  logic                 acq_ok,
    output logic                 pd_up,
    output logic                 pd_dn,
    output logic                 rx_bit,
    output logic signed [CW-1:0] ctrl_word
);

    logic                 step_up;
    logic                 step_dn;
    pd_out_t              vq;
    logic signed [CW-1:0] integ;

    bbpd_vote u_vote (
        .clk      (clk),
        .rst      (rst),
        .smp_mid  (smp_mid),
        .smp_edge (smp_edge),
        .smp_next (smp_next),
        .smp_vld  (smp_vld),
        .acq_ok   (acq_ok),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .out_q    (vq)
    );

    bbpd_integ #(.CW(CW), .GAIN_I(GAIN_I), .INT_LIM(INT_LIM)) u_integ (
        .clk     (clk),
        .rst     (rst),
        .step_up (step_up),
        .step_dn (step_dn),
        .integ_o (integ)
    );

    bbpd_mix #(.CW(CW), .KICK(KICK)) u_mix (
        .integ_i (integ),
        .up_i    (vq.up),
        .dn_i    (vq.dn),
        .word_o  (ctrl_word)
    );

    assign pd_up  = vq.up;
    assign pd_dn  = vq.dn;
    assign rx_bit = vq.bit_q;

    // R4: retimed bit holds between strobes
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp_vld)) |-> $stable(rx_bit));

    // R6: without a strobe the control word carries no kick and does not move
    a_r6_no_kick_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && !$past(smp_vld) && !$past(pd_up) && !$past(pd_dn))
            |-> $stable(ctrl_word));

endmodule

// File: tb/bangbang_pd_tb.sv
module bangbang_pd_tb;

    localparam int CW      = 16;
    localparam int KICK    = 64;
    localparam int GAIN_I  = 4;
    localparam int INT_LIM = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_mid = 1'b0, smp_edge = 1'b0, smp_next = 1'b0, smp_vld = 1'b0, acq_ok = 1'b0;
    logic pd_up, pd_dn, rx_bit;
    logic signed [CW-1:0] ctrl_word;

    int n_chk  = 0;
    int n_fail = 0;

    int m_up = 0, m_dn = 0, m_bit = 0, m_int = 0;

    always #5 clk = ~clk;

    bangbang_pd #(.CW(CW), .KICK(KICK), .GAIN_I(GAIN_I), .INT_LIM(INT_LIM)) u_dut (
        .clk(clk), .rst(rst), .smp_mid(smp_mid), .smp_edge(smp_edge), .smp_next(smp_next),
        .smp_vld(smp_vld), .acq_ok(acq_ok), .pd_up(pd_up), .pd_dn(pd_dn),
        .rx_bit(rx_bit), .ctrl_word(ctrl_word)
    );

    function automatic int sat_model(input int v);
        if (v > INT_LIM)  return INT_LIM;
        if (v < -INT_LIM) return -INT_LIM;
        return v;
    endfunction

    function automatic int expect_word(input int integ, input int up, input int dn);
        return integ + (up != 0 ? KICK : (dn != 0 ? -KICK : 0));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge.
    task automatic cyc(input logic a, input logic t, input logic b, input logic v,
                       input logic en, input logic r, input string wtag);
        string ptag;
        int late, early;
        smp_mid = a; smp_edge = t; smp_next = b; smp_vld = v; acq_ok = en; rst = r;
        @(posedge clk);
        late  = (a != b) && (t == b);
        early = (a != b) && (t == a);
        if (r) begin
            m_up = 0; m_dn = 0; m_bit = 0; m_int = 0;
        end else begin
            m_up = (v && en && late)  ? 1 : 0;
            m_dn = (v && en && early) ? 1 : 0;
            if (v) m_bit = a;
            if (m_up != 0) m_int = sat_model(m_int + GAIN_I);
            if (m_dn != 0) m_int = sat_model(m_int - GAIN_I);
        end
        if (r)            ptag = "R10";
        else if (!v)      ptag = "R5";
        else if (!en)     ptag = "R9";
        else if (a == b)  ptag = "R1";
        else if (early)   ptag = "R2";
        else              ptag = "R3";
        @(negedge clk);
        chk(ptag, "pd_up", int'(pd_up), m_up);
        chk(ptag, "pd_dn", int'(pd_dn), m_dn);
        chk(r ? "R10" : "R4", "rx_bit", int'(rx_bit), m_bit);
        chk(r ? "R10" : wtag, "ctrl_word", int'(ctrl_word), expect_word(m_int, m_up, m_dn));
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R10: reset state
        cyc(1, 0, 1, 1, 1, 1, "R10");
        cyc(0, 1, 1, 1, 1, 1, "R10");

        // R1: no transition, both levels, edge sample disagreeing too
        cyc(0, 0, 0, 1, 1, 0, "R7");
        cyc(1, 0, 1, 1, 1, 0, "R7");
        cyc(0, 1, 0, 1, 1, 0, "R7");
        // R2: early -> down with kick
        cyc(0, 0, 1, 1, 1, 0, "R6");
        cyc(1, 1, 0, 1, 1, 0, "R6");
        // R5: idle cycle drops kick, word holds
        cyc(1, 1, 0, 0, 1, 0, "R6");
        // R3: late -> up
        cyc(0, 1, 1, 1, 1, 0, "R6");
        cyc(1, 0, 0, 1, 1, 0, "R6");
        cyc(0, 0, 0, 0, 1, 0, "R6");
        // R9: gate low blocks decisions, data still moves
        cyc(0, 1, 1, 1, 0, 0, "R9");
        cyc(1, 1, 0, 1, 0, 0, "R9");
        // R4: data holds across idle cycles
        cyc(0, 0, 0, 0, 1, 0, "R4");
        cyc(1, 1, 1, 0, 1, 0, "R4");

        // R8: drive to positive then negative limit
        for (int i = 0; i < 560; i++) cyc(0, 1, 1, 1, 1, 0, "R8");
        for (int i = 0; i < 1100; i++) cyc(1, 1, 0, 1, 1, 0, "R8");
        // R8: recover from negative limit
        cyc(0, 1, 1, 1, 1, 0, "R8");

        // R10: synchronous reset mid-run with active stimulus
        cyc(0, 1, 1, 1, 1, 1, "R10");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic a, t, b, v, e;
            a = 1'($urandom);
            t = 1'($urandom);
            b = 1'($urandom);
            v = ($urandom % 10) < 8;
            e = ($urandom % 10) < 9;
            cyc(a, t, b, v, e, 0, "R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule